// File: doc/BRIEF.md
# SDRAM Bank Command Tracker

This block watches the command bus of an SDRAM device and follows the life of a single bank: it opens, it reads or writes in bursts, and it closes again through precharge, either on an explicit command or by auto precharge. It decodes the chip-select and the three strobe lines, takes a bank-match input that says whether the current command targets this bank, and takes an auto-precharge flag that qualifies READ and WRITE. From these it keeps the bank state and checks each command against that state and against the row-to-column delay, the precharge period and the burst length. All three are run-time cycle counts.

The block drives nothing on the memory bus. It sits beside a controller or a memory model as a protocol monitor. The current state is visible as a 3-bit code. An illegal command raises a one-cycle flag, and a ready output shows when the bank can take a new row or column command. A chip with several banks uses one instance per bank, with each bank-match input tied to a compare of the bank address.

Top module: `bankTracker`

## Requirements
- R1: After reset the state code is 0 (idle), the illegal flag is low and ready is high. The state codes are: 0 idle, 1 row opening, 2 row open, 3 read burst, 4 write burst, 5 read with auto precharge, 6 write with auto precharge, 7 precharging.
- R2: With `csN` low and `bankHit` high, the command is taken from {rasN,casN,weN}: 011 activate, 101 read, 100 write, 010 precharge, 001 refresh, 000 mode load, 110 burst stop, 111 no-op. When `csN` is high or `bankHit` is low, the bank sees a no-op and the command is never flagged.
- R3: A clock edge is evaluated only when `cke` is high at that edge and was high at the previous edge. At any other edge the state and timers hold and no flag is raised.
- R4: After activate at edge e (code 1), a read or write is legal from edge e+cfgRcd onward. Before that it is flagged. A `cfgRcd` of 0 or 1 opens the row at once (code 2).
- R5: After precharge at edge e (code 7), activate is legal from edge e+cfgRp onward. A `cfgRp` of 0 or 1 returns straight to idle.
- R6: In idle, activate, refresh, mode load and precharge are legal, and refresh, mode load and precharge leave the bank idle. Read, write and burst stop are flagged.
- R7: With the row open, read, write and precharge are legal. Activate, refresh, mode load and burst stop are flagged.
- R8: A read or write without auto precharge shows code 3 or 4 for cfgBurst-1 cycles and then returns to code 2 by itself. A burst length of 0 or 1 stays at code 2.
- R9: During a burst without auto precharge, a read or write restarts the burst from the new edge. Precharge truncates it and starts precharging. Burst stop returns the bank to code 2. Activate, refresh and mode load are flagged.
- R10: A read or write with auto precharge at edge e shows code 5 or 6 and returns to idle so that activate is legal from edge e+cfgBurst+cfgRp onward. The same holds in codes 1 and 7: any command other than a no-op is flagged.
- R11: An illegal command raises `illegalCmd` for exactly the cycle after its edge and is otherwise ignored: the state does not change and timers keep counting.
- R12: `bankReady` is high exactly when the state code is 0 or 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| cke | input | 1 | Clock enable as seen on the bus |
| csN | input | 1 | Chip select, active low |
| rasN | input | 1 | Row strobe, active low |
| casN | input | 1 | Column strobe, active low |
| weN | input | 1 | Write strobe, active low |
| apFlag | input | 1 | Auto-precharge qualifier for read and write |
| bankHit | input | 1 | Command addresses this bank |
| cfgRcd | input | CNT_W | Activate-to-column delay in cycles |
| cfgRp | input | CNT_W | Precharge period in cycles |
| cfgBurst | input | CNT_W | Burst length in cycles |
| stateCode | output | 3 | Current bank state code |
| illegalCmd | output | 1 | One-cycle pulse for a command not allowed in the state |
| bankReady | output | 1 | Bank is idle or has its row open |

## Verification
The hardest cases to reach are the window edges: the exact cycle at which a row-opening, precharge or auto-precharge wait ends. This is worst when an illegal command lands inside the window and must not disturb the remaining count. The bench gets there by sweeping the gap between an opening command and its follow-up over every offset on both sides of the boundary, for each small setting of the delay, the precharge period and the burst length. Before the follow-up it checks the state that the gap arithmetic predicts, and after it the flag. Burst restart is separated from a burst that simply runs out by sampling the state at a cycle where the two cases disagree.

// File: rtl/bank_trk_pkg.sv
package bank_trk_pkg;

  typedef enum logic [2:0] {
    ST_IDLE       = 3'd0,
    ST_ACTIVATING = 3'd1,
    ST_ROWACT     = 3'd2,
    ST_READ       = 3'd3,
    ST_WRITE      = 3'd4,
    ST_READ_AP    = 3'd5,
    ST_WRITE_AP   = 3'd6,
    ST_PRECHG     = 3'd7
  } bankState_t;

  typedef enum logic [3:0] {
    CMD_INHIBIT,
    CMD_NOP,
    CMD_ACT,
    CMD_RD,
    CMD_WR,
    CMD_PRE,
    CMD_REF,
    CMD_LMR,
    CMD_BST
  } busCmd_t;

  typedef enum logic [1:0] {
    LD_RCD,
    LD_RP,
    LD_BURST,
    LD_BURST_RP
  } loadSel_t;

  // control -> datapath strobes
  typedef struct packed {
    logic     load;
    loadSel_t sel;
    logic     count;
  } timerStrobe_t;

  // datapath -> control status
  typedef struct packed {
    logic isLast;
    logic rcdZero;
    logic rpZero;
    logic burstZero;
  } timerFlags_t;

endpackage

// File: rtl/cmdDecode.sv
module cmdDecode
  import bank_trk_pkg::*;
(
  input  logic    csN,
  input  logic    rasN,
  input  logic    casN,
  input  logic    weN,
  input  logic    bankHit,
  output busCmd_t cmd
);

  always_comb begin
    if (csN) begin
      cmd = CMD_INHIBIT;
    end else if (!bankHit) begin
      cmd = CMD_NOP;
    end else begin
      case ({rasN, casN, weN})
        3'b011:  cmd = CMD_ACT;
        3'b101:  cmd = CMD_RD;
        3'b100:  cmd = CMD_WR;
        3'b010:  cmd = CMD_PRE;
        3'b001:  cmd = CMD_REF;
        3'b000:  cmd = CMD_LMR;
        3'b110:  cmd = CMD_BST;
        default: cmd = CMD_NOP;
      endcase
    end
  end

endmodule

// File: rtl/bankTimer.sv
module bankTimer
  import bank_trk_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  timerStrobe_t     strb,
  input  logic [CNT_W-1:0] cfgRcd,
  input  logic [CNT_W-1:0] cfgRp,
  input  logic [CNT_W-1:0] cfgBurst,
  output timerFlags_t      flags
);

  localparam int SUM_W = CNT_W + 1;

  // a programmed zero behaves as one cycle
  function automatic logic [SUM_W-1:0] effCycles(input logic [CNT_W-1:0] v);
    return (v == '0) ? SUM_W'(1) : {1'b0, v};
  endfunction

  logic [SUM_W-1:0] timerQ;
  logic [SUM_W-1:0] loadVal;
  logic [SUM_W-1:0] rcdEff, rpEff, burstEff;

  assign rcdEff   = effCycles(cfgRcd);
  assign rpEff    = effCycles(cfgRp);
  assign burstEff = effCycles(cfgBurst);

  always_comb begin
    case (strb.sel)
      LD_RCD:      loadVal = rcdEff - SUM_W'(1);
      LD_RP:       loadVal = rpEff - SUM_W'(1);
      LD_BURST:    loadVal = burstEff - SUM_W'(1);
      default:     loadVal = burstEff + rpEff - SUM_W'(1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      timerQ <= '0;
    end else if (strb.load) begin
      timerQ <= loadVal;
    end else if (strb.count && timerQ != '0) begin
      timerQ <= timerQ - SUM_W'(1);
    end
  end

  assign flags.isLast    = (timerQ == SUM_W'(1));
  assign flags.rcdZero   = (rcdEff == SUM_W'(1));
  assign flags.rpZero    = (rpEff == SUM_W'(1));
  assign flags.burstZero = (burstEff == SUM_W'(1));

endmodule

// File: rtl/bankCtrl.sv
module bankCtrl
  import bank_trk_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         cke,
  input  busCmd_t      cmd,
  input  logic         apFlag,
  input  timerFlags_t  flags,
  output timerStrobe_t strb,
  output bankState_t   stateQ,
  output logic         illegalQ
);

  logic       ckePrevQ;
  logic       tracked;
  logic       legal;
  logic       realCmd;
  bankState_t nextState;
  bankState_t accState;
  bankState_t preState;
  logic       accLoad;
  loadSel_t   accSel;

  assign tracked = cke & ckePrevQ;
  assign realCmd = (cmd != CMD_NOP) && (cmd != CMD_INHIBIT);

  // target of a column command, shared by row-open and burst states
  always_comb begin
    accState = ST_ROWACT;
    accLoad  = 1'b0;
    accSel   = LD_BURST;
    if (apFlag) begin
      accState = (cmd == CMD_RD) ? ST_READ_AP : ST_WRITE_AP;
      accLoad  = 1'b1;
      accSel   = LD_BURST_RP;
    end else if (!flags.burstZero) begin
      accState = (cmd == CMD_RD) ? ST_READ : ST_WRITE;
      accLoad  = 1'b1;
    end
    preState = flags.rpZero ? ST_IDLE : ST_PRECHG;
  end

  always_comb begin
    nextState = stateQ;
    legal     = 1'b1;
    strb      = '0;
    case (stateQ)
      ST_IDLE: begin
        case (cmd)
          CMD_ACT: begin
            if (flags.rcdZero) begin
              nextState = ST_ROWACT;
            end else begin
              nextState = ST_ACTIVATING;
              strb.load = 1'b1;
              strb.sel  = LD_RCD;
            end
          end
          CMD_RD, CMD_WR, CMD_BST: legal = 1'b0;
          default: ;
        endcase
      end
      ST_ROWACT: begin
        case (cmd)
          CMD_RD, CMD_WR: begin
            nextState = accState;
            strb.load = accLoad;
            strb.sel  = accSel;
          end
          CMD_PRE: begin
            nextState = preState;
            strb.load = !flags.rpZero;
            strb.sel  = LD_RP;
          end
          CMD_ACT, CMD_REF, CMD_LMR, CMD_BST: legal = 1'b0;
          default: ;
        endcase
      end
      ST_READ, ST_WRITE: begin
        strb.count = 1'b1;
        if (flags.isLast) nextState = ST_ROWACT;
        case (cmd)
          CMD_RD, CMD_WR: begin
            nextState  = accState;
            strb.count = 1'b0;
            strb.load  = accLoad;
            strb.sel   = accSel;
          end
          CMD_PRE: begin
            nextState  = preState;
            strb.count = 1'b0;
            strb.load  = !flags.rpZero;
            strb.sel   = LD_RP;
          end
          CMD_BST: begin
            nextState  = ST_ROWACT;
            strb.count = 1'b0;
          end
          CMD_ACT, CMD_REF, CMD_LMR: legal = 1'b0;
          default: ;
        endcase
      end
      default: begin
        // timed windows: opening, precharging, auto-precharge bursts
        strb.count = 1'b1;
        if (flags.isLast) begin
          nextState = (stateQ == ST_ACTIVATING) ? ST_ROWACT : ST_IDLE;
        end
        if (realCmd) legal = 1'b0;
      end
    endcase
    if (!tracked) begin
      nextState = stateQ;
      legal     = 1'b1;
      strb      = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ   <= ST_IDLE;
      illegalQ <= 1'b0;
      ckePrevQ <= 1'b1;
    end else begin
      stateQ   <= nextState;
      illegalQ <= tracked & ~legal;
      ckePrevQ <= cke;
    end
  end

endmodule

// File: rtl/bankTracker.sv
module bankTracker
  import bank_trk_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cke,
  input  logic             csN,
  input  logic             rasN,
  input  logic             casN,
  input  logic             weN,
  input  logic             apFlag,
  input  logic             bankHit,
  input  logic [CNT_W-1:0] cfgRcd,
  input  logic [CNT_W-1:0] cfgRp,
  input  logic [CNT_W-1:0] cfgBurst,
  output logic [2:0]       stateCode,
  output logic             illegalCmd,
  output logic             bankReady
);

  busCmd_t      cmd;
  timerStrobe_t strb;
  timerFlags_t  flags;
  bankState_t   stateQ;

  cmdDecode u_decode (
    .csN     (csN),
    .rasN    (rasN),
    .casN    (casN),
    .weN     (weN),
    .bankHit (bankHit),
    .cmd     (cmd)
  );

  bankCtrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cke      (cke),
    .cmd      (cmd),
    .apFlag   (apFlag),
    .flags    (flags),
    .strb     (strb),
    .stateQ   (stateQ),
    .illegalQ (illegalCmd)
  );

  bankTimer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .cfgRcd   (cfgRcd),
    .cfgRp    (cfgRp),
    .cfgBurst (cfgBurst),
    .flags    (flags)
  );

  assign stateCode = stateQ;
  assign bankReady = (stateQ == ST_IDLE) || (stateQ == ST_ROWACT);

endmodule

// File: rtl/bankTrackerChk.sv
module bankTrackerChk (
  input logic       clk,
  input logic       rstN,
  input logic       cke,
  input logic       csN,
  input logic       rasN,
  input logic       casN,
  input logic       weN,
  input logic       bankHit,
  input logic [2:0] stateCode,
  input logic       illegalCmd
);

  logic ckeSeenQ;
  always_ff @(posedge clk) begin
    if (!rstN) ckeSeenQ <= 1'b1;
    else       ckeSeenQ <= cke;
  end

  assert_hold_without_cke_R3: assert property (@(posedge clk) disable iff (!rstN)
    !cke |=> $stable(stateCode));

  assert_flag_needs_cke_R3: assert property (@(posedge clk) disable iff (!rstN)
    illegalCmd |-> $past(cke));

  assert_foreign_quiet_R2: assert property (@(posedge clk) disable iff (!rstN)
    (csN || !bankHit) |=> !illegalCmd);

  assert_idle_read_flagged_R6: assert property (@(posedge clk) disable iff (!rstN)
    (cke && ckeSeenQ && !csN && bankHit && stateCode == 3'd0 &&
     {rasN, casN, weN} == 3'b101) |=> illegalCmd);

  assert_opening_exit_R4: assert property (@(posedge clk) disable iff (!rstN)
    stateCode == 3'd1 |=> (stateCode == 3'd1 || stateCode == 3'd2));

  assert_precharge_exit_R5: assert property (@(posedge clk) disable iff (!rstN)
    stateCode == 3'd7 |=> (stateCode == 3'd7 || stateCode == 3'd0));

  assert_autopre_exit_R10: assert property (@(posedge clk) disable iff (!rstN)
    (stateCode == 3'd5 || stateCode == 3'd6) |=>
      (stateCode == $past(stateCode) || stateCode == 3'd0));

endmodule

bind bankTracker bankTrackerChk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .cke        (cke),
  .csN        (csN),
  .rasN       (rasN),
  .casN       (casN),
  .weN        (weN),
  .bankHit    (bankHit),
  .stateCode  (stateCode),
  .illegalCmd (illegalCmd)
);

// File: tb/test_bankTracker.sv
module test_bankTracker;

  localparam int CNT_W = 4;
  localparam logic [2:0] C_ACT = 3'b011, C_RD = 3'b101, C_WR = 3'b100,
                         C_PRE = 3'b010, C_REF = 3'b001, C_LMR = 3'b000,
                         C_BST = 3'b110, C_NOP = 3'b111;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cke = 1'b1, csN = 1'b1, rasN = 1'b1, casN = 1'b1, weN = 1'b1;
  logic apFlag = 1'b0, bankHit = 1'b1;
  logic [CNT_W-1:0] cfgRcd = 4'd1, cfgRp = 4'd1, cfgBurst = 4'd1;
  logic [2:0] stateCode;
  logic illegalCmd, bankReady;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5ns clk = ~clk;

  bankTracker #(.CNT_W(CNT_W)) i_bankTracker (
    .clk(clk), .rstN(rstN), .cke(cke), .csN(csN), .rasN(rasN), .casN(casN),
    .weN(weN), .apFlag(apFlag), .bankHit(bankHit), .cfgRcd(cfgRcd),
    .cfgRp(cfgRp), .cfgBurst(cfgBurst), .stateCode(stateCode),
    .illegalCmd(illegalCmd), .bankReady(bankReady)
  );

  task automatic check(input int act, input int exp, input string tag);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [2:0] c, input logic ap, input logic hit,
                       input logic cs, input logic ck);
    @(negedge clk);
    {rasN, casN, weN} = c;
    apFlag = ap; bankHit = hit; csN = cs; cke = ck;
    @(posedge clk);
    #1ns;
  endtask

  task automatic issue(input logic [2:0] c, input logic ap);
    drive(c, ap, 1'b1, 1'b0, 1'b1);
  endtask

  task automatic nop();
    drive(C_NOP, 1'b0, 1'b1, 1'b0, 1'b1);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; cke = 1'b1; csN = 1'b1; {rasN, casN, weN} = C_NOP; apFlag = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic setCfg(input int rcd, input int rp, input int bl);
    cfgRcd = CNT_W'(rcd); cfgRp = CNT_W'(rp); cfgBurst = CNT_W'(bl);
  endtask

  function automatic bit isOneOf3(input logic [2:0] c, input logic [2:0] a,
                                  input logic [2:0] b, input logic [2:0] d);
    return (c == a) || (c == b) || (c == d);
  endfunction

  initial begin
    // R1 reset state
    setCfg(1, 1, 1);
    doReset();
    #1ns;
    check(stateCode, 0, "R1 reset state");
    check(illegalCmd, 0, "R1 reset flag");
    check(bankReady, 1, "R1 reset ready");

    // R6 / R7: every command in idle and with the row open
    for (int k = 0; k < 8; k++) begin
      logic [2:0] c = 3'(k);
      doReset();
      issue(c, 1'b0);
      check(illegalCmd, isOneOf3(c, C_RD, C_WR, C_BST), "R6 idle legality");
      check(stateCode, (c == C_ACT) ? 2 : 0, "R6 idle next state");
      doReset();
      issue(C_ACT, 1'b0);
      issue(c, 1'b0);
      check(illegalCmd, isOneOf3(c, C_ACT, C_REF, C_LMR) || c == C_BST,
            "R7 row open legality");
      check(stateCode, (c == C_PRE) ? 0 : 2, "R7 row open next state");
    end

    // R4 / R11 / R12: opening window sweep
    for (int rcd = 1; rcd <= 4; rcd++) begin
      for (int g = 1; g <= 5; g++) begin
        int expSt;
        setCfg(rcd, 1, 1);
        doReset();
        issue(C_ACT, 1'b0);
        repeat (g - 1) nop();
        check(stateCode, (g - 1 >= rcd - 1) ? 2 : 1, "R4 state before column");
        issue(C_RD, 1'b0);
        check(illegalCmd, (g < rcd) ? 1 : 0, "R4 read vs rcd window");
        expSt = (g >= rcd - 1) ? 2 : 1;
        check(stateCode, expSt, "R11 illegal ignored, timer runs");
        check(bankReady, (expSt == 2) ? 1 : 0, "R12 ready");
        nop();
        check(illegalCmd, 0, "R11 flag lasts one cycle");
      end
    end

    // R5: precharge window sweep
    for (int rp = 1; rp <= 4; rp++) begin
      for (int g = 1; g <= 5; g++) begin
        setCfg(1, rp, 1);
        doReset();
        issue(C_ACT, 1'b0);
        issue(C_PRE, 1'b0);
        repeat (g - 1) nop();
        check(stateCode, (g - 1 >= rp - 1) ? 0 : 7, "R5 state before activate");
        issue(C_ACT, 1'b0);
        check(illegalCmd, (g < rp) ? 1 : 0, "R5 activate vs rp window");
      end
    end

    // R8: burst runs out by itself
    for (int bl = 1; bl <= 4; bl++) begin
      for (int w = 0; w < 2; w++) begin
        setCfg(1, 1, bl);
        doReset();
        issue(C_ACT, 1'b0);
        issue((w == 0) ? C_RD : C_WR, 1'b0);
        for (int j = 0; j <= bl; j++) begin
          if (j > 0) nop();
          check(stateCode, (j < bl - 1) ? ((w == 0) ? 3 : 4) : 2, "R8 burst length");
        end
      end
    end

    // R9: commands inside a running burst
    for (int k = 0; k < 5; k++) begin
      logic [2:0] c;
      int expSt;
      c = (k == 0) ? C_RD : (k == 1) ? C_WR : (k == 2) ? C_PRE : (k == 3) ? C_BST : C_ACT;
      expSt = (k == 0) ? 3 : (k == 1) ? 4 : (k == 2) ? 7 : (k == 3) ? 2 : 3;
      setCfg(1, 2, 4);
      doReset();
      issue(C_ACT, 1'b0);
      issue(C_RD, 1'b0);
      issue(c, 1'b0);
      check(illegalCmd, (k == 4) ? 1 : 0, "R9 burst command legality");
      check(stateCode, expSt, "R9 burst command effect");
      if (k == 0) begin
        repeat (2) nop();
        check(stateCode, 3, "R9 restart extends burst");
        nop();
        check(stateCode, 2, "R9 restarted burst ends");
      end
    end

    // R10: auto precharge window sweep
    for (int bl = 1; bl <= 3; bl++) begin
      for (int rp = 1; rp <= 3; rp++) begin
        for (int g = 1; g <= 7; g++) begin
          bit rd = (g % 2) == 1;
          setCfg(1, rp, bl);
          doReset();
          issue(C_ACT, 1'b0);
          issue(rd ? C_RD : C_WR, 1'b1);
          check(stateCode, rd ? 5 : 6, "R10 auto precharge state");
          repeat (g - 1) nop();
          check(stateCode, (g - 1 >= bl + rp - 1) ? 0 : (rd ? 5 : 6),
                "R10 state before activate");
          issue(C_ACT, 1'b0);
          check(illegalCmd, (g < bl + rp) ? 1 : 0, "R10 activate vs burst+rp");
        end
      end
    end

    // R2: commands not addressed to this bank
    setCfg(1, 1, 1);
    doReset();
    drive(C_RD, 1'b0, 1'b0, 1'b0, 1'b1);
    check(illegalCmd, 0, "R2 other bank read ignored");
    drive(C_RD, 1'b0, 1'b1, 1'b1, 1'b1);
    check(illegalCmd, 0, "R2 deselected read ignored");
    drive(C_ACT, 1'b0, 1'b0, 1'b0, 1'b1);
    check(stateCode, 0, "R2 other bank activate ignored");

    // R3: clock enable gating
    doReset();
    drive(C_ACT, 1'b0, 1'b1, 1'b0, 1'b0);
    check(stateCode, 0, "R3 activate with cke low held");
    check(illegalCmd, 0, "R3 no flag with cke low");
    drive(C_RD, 1'b0, 1'b1, 1'b0, 1'b1);
    check(illegalCmd, 0, "R3 first edge after cke rise untracked");
    drive(C_RD, 1'b0, 1'b1, 1'b0, 1'b1);
    check(illegalCmd, 1, "R3 tracking resumes");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog R1 actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule